// File: doc/BRIEF.md
# USB Device Suspend and Wakeup Controller

This block decides when a USB device drops into its low-power suspended state and when it leaves it. It watches a one-cycle strobe that marks bus activity. When that strobe has been absent for three milliseconds of prescaled time, the block enters suspend. It then holds the PHY in its own low-power mode and may raise a suspend interrupt.

A device can leave suspend in two ways. In the first, the host signals resume, which line-state logic reports as a strobe; the block returns to normal operation and may raise a resume interrupt. In the second, software sets a wakeup-request bit. The block then drives resume signaling onto the bus for as long as that bit stays set.

A millisecond guard measures how long the wakeup request is held. It raises an overrun status if the request outlasts the allowed limit. The length of a millisecond is a cycle count supplied by a prescaler input, so the block works at any core clock.

Top module: `usb_suspend_ctl`

## Requirements
- R1: With `ms_cycles` = P (P of 2 or more), the block enters suspend (`suspended` = 1) exactly 3·P clock cycles after the last cycle in which `bus_active` was sampled high, or after the cycle in which it last left suspend or wakeup.
- R2: A high `bus_active` restarts the idle measurement from zero. The idle measurement does not advance while suspended or while driving wakeup.
- R3: `susp_irq` is a single-cycle pulse in the cycle in which `suspended` first reads 1. It pulses only if `susp_irq_en` was 1 in the cycle before; otherwise it stays 0.
- R4: `phy_suspend` is 1 exactly in the cycles in which `suspended` is 1, and is 0 while `resume_drive` is 1.
- R5: While suspended, a sampled `resume_seen` returns the block to normal operation on the next cycle. It raises a one-cycle `resume_irq` only if `resume_irq_en` is 1. `resume_seen` takes priority over `wake_req` in the same cycle.
- R6: While suspended, a sampled `wake_req` = 1 clears `suspended` and `phy_suspend` and sets `resume_drive` on the next cycle. `resume_drive` stays 1 while `wake_req` stays 1, and falls one cycle after `wake_req` is sampled 0. No `resume_irq` is raised for a software wakeup.
- R7: `wake_overrun` rises exactly (15+1)·P cycles after `resume_drive` rose if `wake_req` is held, that is once the request is beyond 15 ms. It falls together with `resume_drive`, and stays 0 for any shorter hold.
- R8: `wake_req` is ignored when not suspended: `resume_drive` stays 0 and `suspended` is unchanged.
- R9: `ms_cycles` values of 0 and 1 both give a one-cycle millisecond, so suspend follows 3 cycles after the last activity.
- R10: After reset, `suspended`, `phy_suspend`, `resume_drive`, `susp_irq`, `resume_irq` and `wake_overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_cycles | input | 16 | Clock cycles per millisecond tick (0 and 1 both mean one cycle) |
| bus_active | input | 1 | Strobe: bus activity seen this cycle |
| resume_seen | input | 1 | Strobe: host resume signaling detected |
| susp_irq_en | input | 1 | Enable for the suspend interrupt |
| resume_irq_en | input | 1 | Enable for the resume interrupt |
| wake_req | input | 1 | Software wakeup-request level |
| suspended | output | 1 | Block is in suspend |
| phy_suspend | output | 1 | PHY low-power control |
| resume_drive | output | 1 | Drive resume signaling onto the bus |
| susp_irq | output | 1 | One-cycle suspend interrupt pulse |
| resume_irq | output | 1 | One-cycle resume interrupt pulse |
| wake_overrun | output | 1 | Wakeup request held beyond the limit |

## Verification
The assertions assume that `wake_req` and `resume_seen` are 0 while reset is held. They also assume that the interrupt enables are steady for the cycle before an entry or exit, because the interrupt checks look one cycle back at those inputs. The stimulus changes inputs only on falling edges and holds the strobes for exactly one cycle. Before each scenario it brings the block back to normal operation with a resume strobe, so no scenario begins from a suspend left over by the previous one. The prescaler is changed only just before an activity strobe, which restarts every measurement.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

    localparam int unsigned PRESC_W = 16;

    typedef logic [PRESC_W-1:0] presc_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SUSP = 2'd1,
        ST_WAKE = 2'd2
    } susp_state_e;

    typedef struct packed {
        logic susp_pulse;
        logic resume_pulse;
    } irq_pair_t;

    // Terminal count of the prescaler; 0 and 1 both give a tick every cycle.
    function automatic presc_t tick_last(input presc_t cycles);
        if (cycles <= presc_t'(1)) begin
            return presc_t'(0);
        end
        return cycles - presc_t'(1);
    endfunction

endpackage

// File: rtl/usb_ms_tick.sv
module usb_ms_tick
    import usb_susp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  presc_t cycles,
    output logic   tick
);
    presc_t cnt_q;
    presc_t last;

    assign last = tick_last(cycles);
    assign tick = !clr && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + presc_t'(1);
        end
    end
endmodule

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
    parameter int unsigned IDLE_MS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic activity,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = $clog2(IDLE_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_MS - 1);

    logic [CW-1:0] ms_q;

    assign expire = run && !activity && tick && (ms_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || activity) begin
            ms_q <= '0;
        end else if (tick && (ms_q != CW'(IDLE_MS))) begin
            ms_q <= ms_q + CW'(1);
        end
    end
endmodule

// File: rtl/usb_wake_guard.sv
module usb_wake_guard #(
    parameter int unsigned LIMIT_MS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic overrun
);
    localparam int unsigned CW = $clog2(LIMIT_MS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(LIMIT_MS);

    logic [CW-1:0] ms_q;
    logic          ovr_q;

    assign overrun = ovr_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ms_q  <= '0;
            ovr_q <= 1'b0;
        end else if (tick && !ovr_q) begin
            ms_q <= ms_q + CW'(1);
            if (ms_q == LIMIT) begin
                ovr_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_suspend_ctl.sv
module usb_suspend_ctl
    import usb_susp_pkg::*;
#(
    parameter int unsigned IDLE_MS       = 3,
    parameter int unsigned WAKE_LIMIT_MS = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] ms_cycles,
    input  logic               bus_active,
    input  logic               resume_seen,
    input  logic               susp_irq_en,
    input  logic               resume_irq_en,
    input  logic               wake_req,
    output logic               suspended,
    output logic               phy_suspend,
    output logic               resume_drive,
    output logic               susp_irq,
    output logic               resume_irq,
    output logic               wake_overrun
);
    susp_state_e state_q, state_d;
    irq_pair_t   irq_q, irq_d;

    logic idle_run, idle_clr, idle_tick, idle_expire;
    logic wake_run, wake_tick;

    assign idle_run = (state_q == ST_RUN);
    assign idle_clr = !idle_run || bus_active;
    assign wake_run = (state_q == ST_WAKE) && wake_req;

    // Separate prescalers so each measurement starts on its own boundary.
    usb_ms_tick i_idle_tick (
        .clk    (clk),
        .rst    (rst),
        .clr    (idle_clr),
        .cycles (ms_cycles),
        .tick   (idle_tick)
    );

    usb_idle_timer #(.IDLE_MS(IDLE_MS)) i_idle (
        .clk      (clk),
        .rst      (rst),
        .run      (idle_run),
        .activity (bus_active),
        .tick     (idle_tick),
        .expire   (idle_expire)
    );

    usb_ms_tick i_wake_tick (
        .clk    (clk),
        .rst    (rst),
        .clr    (!wake_run),
        .cycles (ms_cycles),
        .tick   (wake_tick)
    );

    usb_wake_guard #(.LIMIT_MS(WAKE_LIMIT_MS)) i_guard (
        .clk     (clk),
        .rst     (rst),
        .run     (wake_run),
        .tick    (wake_tick),
        .overrun (wake_overrun)
    );

    always_comb begin
        state_d = state_q;
        irq_d   = '0;
        unique case (state_q)
            ST_RUN: begin
                if (idle_expire) begin
                    state_d          = ST_SUSP;
                    irq_d.susp_pulse = susp_irq_en;
                end
            end
            ST_SUSP: begin
                // Host resume wins over a simultaneous software request.
                if (resume_seen) begin
                    state_d            = ST_RUN;
                    irq_d.resume_pulse = resume_irq_en;
                end else if (wake_req) begin
                    state_d = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (!wake_req) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            irq_q   <= '0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    assign suspended    = (state_q == ST_SUSP);
    assign phy_suspend  = (state_q == ST_SUSP);
    assign resume_drive = (state_q == ST_WAKE);
    assign susp_irq     = irq_q.susp_pulse;
    assign resume_irq   = irq_q.resume_pulse;
endmodule

// File: rtl/usb_suspend_ctl_chk.sv
module usb_suspend_ctl_chk (
    input logic clk,
    input logic rst,
    input logic bus_active,
    input logic resume_seen,
    input logic susp_irq_en,
    input logic resume_irq_en,
    input logic wake_req,
    input logic suspended,
    input logic phy_suspend,
    input logic resume_drive,
    input logic susp_irq,
    input logic resume_irq,
    input logic wake_overrun
);
    // R3: pulse only on the entry cycle and only when enabled
    p_susp_irq_entry_r3: assert property (@(posedge clk) disable iff (rst)
        susp_irq |-> suspended && !$past(suspended) && $past(susp_irq_en));

    // R3: single-cycle pulse
    p_susp_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
        susp_irq |=> !susp_irq);

    // R4: PHY control follows the suspend state and is off while waking
    p_phy_off_in_wake_r4: assert property (@(posedge clk) disable iff (rst)
        resume_drive |-> !phy_suspend && !suspended);

    // R5: host resume exits suspend
    p_resume_exit_r5: assert property (@(posedge clk) disable iff (rst)
        suspended && resume_seen |=> !suspended && !resume_drive);

    // R5: resume interrupt only from suspend and when enabled
    p_resume_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
        resume_irq |-> $past(suspended) && $past(resume_seen) && $past(resume_irq_en));

    // R6: drive only follows a held request and ends when it drops
    p_drive_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
        resume_drive |-> $past(wake_req));

    // R7: overrun only while driving wakeup
    p_overrun_in_wake_r7: assert property (@(posedge clk) disable iff (rst)
        wake_overrun |-> resume_drive);

    // R8: request outside suspend starts no wakeup
    p_ignore_req_r8: assert property (@(posedge clk) disable iff (rst)
        !suspended && !resume_drive && wake_req |=> !resume_drive);

    // R2: activity cannot put the block into suspend on the next cycle
    p_activity_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        !suspended && !resume_drive && bus_active |=> !suspended);
endmodule

bind usb_suspend_ctl usb_suspend_ctl_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_active    (bus_active),
    .resume_seen   (resume_seen),
    .susp_irq_en   (susp_irq_en),
    .resume_irq_en (resume_irq_en),
    .wake_req      (wake_req),
    .suspended     (suspended),
    .phy_suspend   (phy_suspend),
    .resume_drive  (resume_drive),
    .susp_irq      (susp_irq),
    .resume_irq    (resume_irq),
    .wake_overrun  (wake_overrun)
);

// File: tb/test_usb_suspend_ctl.sv
module test_usb_suspend_ctl;
    import usb_susp_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  ms_cycles = 16'd10;
    logic         bus_active = 1'b0;
    logic         resume_seen = 1'b0;
    logic         susp_irq_en = 1'b1;
    logic         resume_irq_en = 1'b1;
    logic         wake_req = 1'b0;
    logic         suspended, phy_suspend, resume_drive;
    logic         susp_irq, resume_irq, wake_overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_suspend_ctl i_usb_suspend_ctl (
        .clk           (clk),
        .rst           (rst),
        .ms_cycles     (ms_cycles),
        .bus_active    (bus_active),
        .resume_seen   (resume_seen),
        .susp_irq_en   (susp_irq_en),
        .resume_irq_en (resume_irq_en),
        .wake_req      (wake_req),
        .suspended     (suspended),
        .phy_suspend   (phy_suspend),
        .resume_drive  (resume_drive),
        .susp_irq      (susp_irq),
        .resume_irq    (resume_irq),
        .wake_overrun  (wake_overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Leave suspend if needed, then strobe activity; returns at the negedge after the strobe edge.
    task automatic restart_active();
        @(negedge clk);
        if (suspended) begin
            resume_seen = 1'b1;
            @(negedge clk);
            resume_seen = 1'b0;
        end
        bus_active = 1'b1;
        @(negedge clk);
        bus_active = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Suspend entry timing; p is cycles per ms (0/1 mean 1).
    task automatic t_entry(input int p, input string req);
        int eff;
        eff = (p <= 1) ? 1 : p;
        ms_cycles = 16'(p);
        restart_active();
        wait_cycles(3 * eff - 1);
        check({req, " not yet suspended"}, int'(suspended), 0);
        @(negedge clk);
        check({req, " suspended at 3 ms"}, int'(suspended), 1);
        check("R4 phy_suspend with suspend", int'(phy_suspend), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 suspended", int'(suspended), 0);
        check("R10 phy_suspend", int'(phy_suspend), 0);
        check("R10 resume_drive", int'(resume_drive), 0);
        check("R10 irqs", int'({susp_irq, resume_irq}), 0);
        check("R10 wake_overrun", int'(wake_overrun), 0);
    endtask

    task automatic t_activity_restart();
        ms_cycles = 16'd10;
        restart_active();
        wait_cycles(25);
        bus_active = 1'b1;
        @(negedge clk);
        bus_active = 1'b0;
        wait_cycles(29);
        check("R2 activity restarts idle count", int'(suspended), 0);
        @(negedge clk);
        check("R2 suspend after full idle", int'(suspended), 1);
        // held in suspend: no count-based change, stays suspended
        wait_cycles(50);
        check("R2 stays suspended", int'(suspended), 1);
    endtask

    task automatic t_susp_irq(input logic en);
        susp_irq_en = en;
        ms_cycles = 16'd10;
        restart_active();
        wait_cycles(29);
        check("R3 no early susp_irq", int'(susp_irq), 0);
        @(negedge clk);
        check("R3 susp_irq on entry", int'(susp_irq), int'(en));
        @(negedge clk);
        check("R3 susp_irq one cycle", int'(susp_irq), 0);
        susp_irq_en = 1'b1;
    endtask

    task automatic t_host_resume(input logic en);
        resume_irq_en = en;
        t_entry(10, "R1");
        resume_seen = 1'b1;
        wake_req = 1'b1;
        @(negedge clk);
        resume_seen = 1'b0;
        wake_req = 1'b0;
        check("R5 exit on resume", int'(suspended), 0);
        check("R5 resume has priority", int'(resume_drive), 0);
        check("R4 phy released", int'(phy_suspend), 0);
        check("R5 resume_irq", int'(resume_irq), int'(en));
        @(negedge clk);
        check("R5 resume_irq one cycle", int'(resume_irq), 0);
        wait_cycles(28);
        check("R1 after resume not yet", int'(suspended), 0);
        @(negedge clk);
        check("R1 idle restarts after resume", int'(suspended), 1);
        resume_irq_en = 1'b1;
    endtask

    task automatic t_wake(input int hold_ms);
        t_entry(10, "R1");
        wake_req = 1'b1;
        @(negedge clk);
        check("R6 drive on request", int'(resume_drive), 1);
        check("R6 suspended cleared", int'(suspended), 0);
        check("R4 phy off in wake", int'(phy_suspend), 0);
        check("R6 no resume_irq", int'(resume_irq), 0);
        if (hold_ms > 15) begin
            wait_cycles(16 * 10 - 1);
            check("R7 no overrun at limit", int'(wake_overrun), 0);
            @(negedge clk);
            check("R7 overrun beyond limit", int'(wake_overrun), 1);
            wait_cycles(5);
        end else begin
            wait_cycles(hold_ms * 10);
            check("R7 no overrun in range", int'(wake_overrun), 0);
            check("R6 drive held", int'(resume_drive), 1);
        end
        wake_req = 1'b0;
        check("R6 drive until sampled", int'(resume_drive), 1);
        @(negedge clk);
        check("R6 drive ends", int'(resume_drive), 0);
        check("R7 overrun cleared", int'(wake_overrun), 0);
        check("R6 back to normal", int'(suspended), 0);
    endtask

    task automatic t_ignore();
        ms_cycles = 16'd10;
        restart_active();
        wake_req = 1'b1;
        wait_cycles(10);
        check("R8 no drive outside suspend", int'(resume_drive), 0);
        check("R8 state unchanged", int'(suspended), 0);
        wake_req = 1'b0;
        wait_cycles(19);
        check("R8 idle count unaffected", int'(suspended), 0);
        @(negedge clk);
        check("R8 suspend on time", int'(suspended), 1);
    endtask

    initial begin
        wait_cycles(3);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_entry(10, "R1");
        t_entry(4, "R1");
        t_entry(0, "R9 presc 0");
        t_entry(1, "R9 presc 1");
        t_activity_restart();
        t_susp_irq(1'b1);
        t_susp_irq(1'b0);
        t_host_resume(1'b1);
        t_host_resume(1'b0);
        t_wake(10);
        t_wake(20);
        t_ignore();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule